// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Time Insertion

This block drives the two switches of a half-bridge from one free-running counter. A 12-bit up-counter advances on each counter-clock enable, and after it reaches its top value it restarts from a programmable reload value, so the reload value sets the PWM period. A duty compare value splits each period into a high phase (from the reload up to the compare value) and a low phase. The main output follows the high phase and the complementary output follows the low phase.

When the gap function is turned on, the output that is switching on is held off for a programmable number of counter ticks after the other output has switched off, so the two switches never conduct together. The gap setting is an 8-bit word: a 7-bit tick count plus an enable bit. It is copied into a shadow register only when the counter wraps, so a new setting never disturbs the period that is running. Each output has its own polarity inversion bit, applied after the gap logic.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: On each clock with `cntEn` high, `cntVal` rises by one. On a tick taken at 4095 it loads `autoReload` instead, and `wrapTick` is high during that tick, which means `cntEn` is high and `cntVal` is 4095. Both output levels follow a counter step two clock edges later.
- R2: After a clock edge with `rstN` low, `cntVal` equals `autoReload`, the shadow gap word is zero (gap off), and both outputs sit low before polarity inversion.
- R3: With the shadow enable bit (bit 7) clear, the main output before inversion is high exactly while the counter is below `dutyCmp`, and the complementary output is its exact inverse, with no gap.
- R4: With the gap on and a nonzero count N (bits 6:0), the main output falls together with the compare crossing, and the complementary output rises N counter ticks later.
- R5: With the gap on and N nonzero, the complementary output falls together with the wrap into the high phase, and the main output rises N counter ticks later.
- R6: With the enable bit set and a count of zero, both outputs stay at their reset level (low before inversion).
- R7: A write to `dtCfg` affects the outputs only after the next wrap tick, which copies it into the shadow register.
- R8: If N is longer than the phase that follows an edge, the delayed output stays low for the whole of that phase, and the delay does not carry over into the next phase.
- R9: `invMain` and `invComp` each invert their own output combinationally. They are applied after the gap logic.
- R10: With both inversion bits clear, `pwmMain` and `pwmComp` are never high together.
- R11: Clocks with `cntEn` low advance neither the counter nor the gap countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cntEn | input | 1 | Counter clock enable (one tick) |
| autoReload | input | 12 | Reload value, sets the period |
| dutyCmp | input | 12 | Compare value that ends the high phase |
| dtCfg | input | 8 | Gap word: bit 7 enable, bits 6:0 tick count |
| invMain | input | 1 | Invert the main output |
| invComp | input | 1 | Invert the complementary output |
| pwmMain | output | 1 | Main PWM output |
| pwmComp | output | 1 | Complementary PWM output |
| cntVal | output | 12 | Current counter value |
| wrapTick | output | 1 | High during a tick taken at the top value |

## Verification
The hardest case to reach from the ports is a gap count longer than the phase it is meant to delay, and in particular a count that is still running when the next edge arrives. The bench sweeps short periods (16 and 32 ticks) against duty points near both ends of the period and gap counts up to 20, so that truncation occurs on both edges. It also rewrites `dtCfg` in the middle of a period and gates `cntEn` in an irregular pattern, which shows that shadow capture and tick counting line up with the wrap.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic tick;       // counter clock enable
    logic wrap;       // tick taken at the top count
    logic phaseEdge;  // phase level differs from its registered copy
  } dpStrobe_t;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,  // gap disabled: straight complement
    MODE_GAP   = 2'd1,  // gap enabled with nonzero count
    MODE_PARK  = 2'd2   // gap enabled with zero count: hold reset level
  } outMode_t;

endpackage

// File: rtl/pwmdt_datapath.sv
module pwmdt_datapath
  import pwmdt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] autoReload,
  input  logic [CNT_W-1:0] dutyCmp,
  input  logic [DT_W:0]    dtCfg,
  output logic [CNT_W-1:0] cnt,
  output logic             atMax,
  output logic             phaseNow,
  output logic             phaseQ,
  output logic             dlyZero,
  output logic             shEn,
  output logic             shValZero
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DT_W:0]   shadow;
  logic [DT_W-1:0] dly;
  logic [DT_W-1:0] shVal;

  assign shVal     = shadow[DT_W-1:0];
  assign shEn      = shadow[DT_W];
  assign shValZero = (shVal == '0);
  assign atMax     = (cnt == CNT_MAX);
  assign phaseNow  = (cnt < dutyCmp);
  assign dlyZero   = (dly == '0);

  // period counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= autoReload;
    end else if (strobe.tick) begin
      if (strobe.wrap) cnt <= autoReload;
      else             cnt <= cnt + 1'b1;
    end
  end

  // shadow copy of the gap word, refreshed only at wrap
  always_ff @(posedge clk) begin
    if (!rstN)            shadow <= '0;
    else if (strobe.wrap) shadow <= dtCfg;
  end

  // registered phase level
  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= 1'b0;
    else       phaseQ <= phaseNow;
  end

  // gap countdown: reload on every phase edge, count down on ticks
  always_ff @(posedge clk) begin
    if (!rstN)                            dly <= '0;
    else if (strobe.phaseEdge)            dly <= shVal;
    else if (strobe.tick && dly != '0)    dly <= dly - 1'b1;
  end

  AST_RELOAD_AFTER_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && atMax) |=> (cnt == $past(autoReload))) else $error("reload"); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && $past(rstN)) |=> ($stable(cnt) && (dly == '0 || $stable(dly) || $past(strobe.phaseEdge)))) else $error("hold"); // R11

  AST_SHADOW_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrap && $past(rstN)) |=> $stable(shadow)) else $error("shadow"); // R7

  AST_DLY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.phaseEdge |=> (dly == $past(shVal))) else $error("dly load"); // R4

endmodule

// File: rtl/pwmdt_control.sv
module pwmdt_control
  import pwmdt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cntEn,
  input  logic      atMax,
  input  logic      phaseNow,
  input  logic      phaseQ,
  input  logic      dlyZero,
  input  logic      shEn,
  input  logic      shValZero,
  input  logic      invMain,
  input  logic      invComp,
  output dpStrobe_t strobe,
  output logic      pwmMain,
  output logic      pwmComp
);

  outMode_t mode;
  logic     nextMain;
  logic     nextComp;
  logic     baseMainQ;
  logic     baseCompQ;

  always_comb begin
    strobe.tick      = cntEn;
    strobe.wrap      = cntEn && atMax;
    strobe.phaseEdge = (phaseNow != phaseQ);
  end

  always_comb begin
    if (!shEn)          mode = MODE_PLAIN;
    else if (shValZero) mode = MODE_PARK;
    else                mode = MODE_GAP;
  end

  always_comb begin
    unique case (mode)
      MODE_PLAIN: begin
        nextMain = phaseQ;
        nextComp = !phaseQ;
      end
      MODE_GAP: begin
        nextMain = phaseQ && dlyZero;
        nextComp = !phaseQ && dlyZero;
      end
      default: begin
        nextMain = 1'b0;
        nextComp = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseMainQ <= 1'b0;
      baseCompQ <= 1'b0;
    end else begin
      baseMainQ <= nextMain;
      baseCompQ <= nextComp;
    end
  end

  assign pwmMain = baseMainQ ^ invMain;
  assign pwmComp = baseCompQ ^ invComp;

  AST_ZERO_DT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PARK) |=> (!baseMainQ && !baseCompQ)) else $error("park"); // R6

  AST_PLAIN_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PLAIN) |=> (baseMainQ != baseCompQ)) else $error("plain"); // R3

endmodule

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen
  import pwmdt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic [CNT_W-1:0] autoReload,
  input  logic [CNT_W-1:0] dutyCmp,
  input  logic [DT_W:0]    dtCfg,
  input  logic             invMain,
  input  logic             invComp,
  output logic             pwmMain,
  output logic             pwmComp,
  output logic [CNT_W-1:0] cntVal,
  output logic             wrapTick
);

  dpStrobe_t strobe;
  logic atMax, phaseNow, phaseQ, dlyZero, shEn, shValZero;

  pwmdt_datapath #(.CNT_W(CNT_W), .DT_W(DT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .autoReload(autoReload), .dutyCmp(dutyCmp), .dtCfg(dtCfg),
    .cnt(cntVal), .atMax(atMax), .phaseNow(phaseNow), .phaseQ(phaseQ),
    .dlyZero(dlyZero), .shEn(shEn), .shValZero(shValZero)
  );

  pwmdt_control ctl_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .atMax(atMax),
    .phaseNow(phaseNow), .phaseQ(phaseQ), .dlyZero(dlyZero),
    .shEn(shEn), .shValZero(shValZero),
    .invMain(invMain), .invComp(invComp),
    .strobe(strobe), .pwmMain(pwmMain), .pwmComp(pwmComp)
  );

  assign wrapTick = strobe.wrap;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    (!invMain && !invComp) |-> !(pwmMain && pwmComp)) else $error("overlap"); // R10

endmodule

// File: tb/pwm_deadtime_gen_tb.sv
`timescale 1ns/1ps
module pwm_deadtime_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic [11:0] autoReload = 12'd4064;
  logic [11:0] dutyCmp = 12'd4080;
  logic [7:0]  dtCfg = 8'd0;
  logic        invMain = 1'b0;
  logic        invComp = 1'b0;
  logic        pwmMain, pwmComp, wrapTick;
  logic [11:0] cntVal;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  string reqTag = "R3";

  always #2.5 clk = ~clk;

  pwm_deadtime_gen dut_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .autoReload(autoReload),
    .dutyCmp(dutyCmp), .dtCfg(dtCfg), .invMain(invMain), .invComp(invComp),
    .pwmMain(pwmMain), .pwmComp(pwmComp), .cntVal(cntVal), .wrapTick(wrapTick)
  );

  // reference: counter, shadow word, ticks elapsed since last phase change
  logic [11:0] mCnt;
  logic [7:0]  mSh;
  logic        mPhQ, mB0, mB1;
  int          mAge, mN;

  always @(posedge clk) begin
    logic ph;
    if (!rstN) begin
      mCnt <= autoReload; mSh <= 8'd0; mPhQ <= 1'b0;
      mAge <= 1000; mN <= 0; mB0 <= 1'b0; mB1 <= 1'b0;
    end else begin
      ph = (mCnt < dutyCmp);
      if (ph != mPhQ) begin mAge <= 0; mN <= int'(mSh[6:0]); end
      else if (cntEn && mAge < 1000) mAge <= mAge + 1;
      mPhQ <= ph;
      if (!mSh[7])            begin mB0 <= mPhQ; mB1 <= !mPhQ; end
      else if (mSh[6:0] == 0) begin mB0 <= 1'b0; mB1 <= 1'b0; end
      else begin
        mB0 <= mPhQ && (mAge >= mN);
        mB1 <= !mPhQ && (mAge >= mN);
      end
      if (cntEn) begin
        if (mCnt == 12'hFFF) begin mCnt <= autoReload; mSh <= dtCfg; end
        else mCnt <= mCnt + 12'd1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R1 cnt", int'(cntVal), int'(mCnt));
    chk("R1 wrap", int'(wrapTick), int'(cntEn && mCnt == 12'hFFF));
    chk({reqTag, " main R5"}, int'(pwmMain), int'(mB0 ^ invMain));
    chk({reqTag, " comp R4"}, int'(pwmComp), int'(mB1 ^ invComp));
    if (!invMain && !invComp)
      chk("R10 overlap", int'(pwmMain && pwmComp), 0);
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic logic [11:0] dutyPick(input int k, input logic [11:0] arr);
    case (k)
      0: return arr + 12'd3;
      1: return arr + 12'd8;
      2: return 12'hFFD;
      3: return 12'd0;
      default: return 12'hFFF;
    endcase
  endfunction

  function automatic logic [7:0] dtPick(input int k);
    case (k)
      0: return 8'h05;   // disabled
      1: return 8'h80;   // enabled, zero
      2: return 8'h83;
      3: return 8'h87;
      default: return 8'h94; // 20 ticks, longer than phases
    endcase
  endfunction

  initial begin
    // R2 reset state
    rstN = 1'b0; cntEn = 1'b1;
    repeat (3) @(negedge clk);
    reqTag = "R2";
    chk("R2 cnt", int'(cntVal), 4064);
    chk("R2 main", int'(pwmMain), 0);
    chk("R2 comp", int'(pwmComp), 0);
    invMain = 1'b1;
    #0.1 chk("R2 R9 inv", int'(pwmMain), 1);
    invMain = 1'b0;
    rstN = 1'b1;
    reqTag = "R3";
    runTicks(40);

    // sweep
    for (int a = 0; a < 2; a++) begin
      for (int d = 0; d < 5; d++) begin
        for (int g = 0; g < 5; g++) begin
          for (int v = 0; v < 2; v++) begin
            autoReload = (a == 0) ? 12'd4064 : 12'd4080;
            dutyCmp = dutyPick(d, autoReload);
            dtCfg = dtPick(g);
            invMain = (v == 1); invComp = (v == 1) && (g == 2);
            case (g)
              0: reqTag = "R3";
              1: reqTag = "R6";
              4: reqTag = "R8";
              default: reqTag = "R4,R5";
            endcase
            if (v == 1) reqTag = {reqTag, " R9"};
            runTicks((a == 0) ? 70 : 40);
          end
        end
      end
    end

    // R7: rewrite gap word mid-period, shadow takes it at wrap only
    invMain = 1'b0; invComp = 1'b0;
    autoReload = 12'd4064; dutyCmp = 12'd4080; dtCfg = 8'h00;
    reqTag = "R7"; runTicks(70);
    dtCfg = 8'h86; runTicks(10);
    dtCfg = 8'h80; runTicks(20);
    dtCfg = 8'h82; runTicks(80);

    // R11: irregular tick gating
    reqTag = "R11"; dtCfg = 8'h85;
    for (int i = 0; i < 400; i++) begin
      cntEn = (i % 3 != 0) && (i % 7 != 2);
      step();
    end
    cntEn = 1'b1;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule